// File: doc/BRIEF.md
# Double-Buffered Serial Transceiver with Control/Status Register

This block is an asynchronous serial transmitter and receiver. Each direction puts a one-word holding register in front of its shift register, so software can queue the next byte while the current frame is still on the wire, or collect a received word while the next frame is already arriving. One 8-bit control/status register serves both directions. It holds the two enable bits, a flag for a free transmit holding register, a flag for a finished reception, and the overrun, framing, parity and summary error flags.

Software drives a small register bus with four addresses. Address 0 is the control/status register, read and write. Address 1 is the transmit holding register, write only. Address 2 returns the low byte of the 16-bit receive word, and address 3 returns its high byte. The serial timing comes from an external tick input that pulses at 16 times the bit rate.

A frame is one low start bit, 8 data bits with the least significant bit first, one even parity bit, and one high stop bit. Each bit lasts 16 ticks. The receiver samples the line near the middle of each bit.

Top module: `sio_duplex`

## Requirements
- R1: After reset, the control/status register reads 0x02 and `txd` is high.
- R2: A transmitted frame is: start 0, then data bits 0 to 7, then the even parity bit (the XOR of the data), then stop 1. Each bit is held for 16 ticks of `baud_tick`.
- R3: Status bit 1 (transmit holding register empty) clears when address 1 is written. It sets when the held byte moves into the shift register. That move happens only while control bit 0 (transmit enable) is 1.
- R4: If the holding register is full when a frame ends, the start bit of the next frame follows the stop bit with no idle time.
- R5: Writing control bit 0 to 0 during a frame lets that frame finish. After that, no held byte is sent until bit 0 is set to 1 again.
- R6: With control bit 2 (receive enable) set, a valid frame sets status bit 3 (receive complete). Address 2 then returns the data byte, and address 3 returns the received parity bit in bit 0 with zeros above it.
- R7: Reading address 2 clears status bit 3. Reading address 3 leaves it unchanged.
- R8: If a frame completes while status bit 3 is 1, status bit 4 (overrun) sets and the receive word keeps its old value. If the frame completes in the same cycle as a read of address 2, the new word is stored and no overrun is flagged.
- R9: A stop bit sampled low sets status bit 5 (framing error). A parity mismatch sets status bit 6 (parity error). Status bit 7 is the OR of bits 4, 5 and 6.
- R10: Writing control bit 2 as 0 drops a partially received frame at once, so that frame never completes. The same write clears status bits 3 to 7.
- R11: Only bits 0 and 2 of the control/status register are writable. Writes to bits 1 and 3 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (the read side effect of address 2 needs it) |
| bus_addr | input | 2 | Register address 0 to 3 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |

## Verification
Two pairs of events can fall in the same clock cycle. First, a completing reception can coincide with a read of the receive low byte. The bench counts cycles from its own first start-bit edge on `rxd` and places the read exactly in the cycle where the stop bit is sampled. It then expects the read to return the old word, the new word to be stored, status bit 3 to stay set, and no overrun. Second, a transmit frame can end in the same cycle that the next held byte is loaded. This is provoked by refilling the holding register at every start bit across a sweep of all 256 byte values. It is judged by sampling `txd` mid-bit and requiring a start bit exactly 16 ticks after each stop-bit sample.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // register bus addresses (software map)
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_TXH  = 2'd1;
  localparam logic [1:0] ADR_RXLO = 2'd2;
  localparam logic [1:0] ADR_RXHI = 2'd3;

  // receiver sequencing
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // control/status image, bit 7 down to bit 0
  typedef struct packed {
    logic err_any;
    logic par_err;
    logic frm_err;
    logic ovr_err;
    logic rx_full;
    logic rx_on;
    logic tx_free;
    logic tx_on;
  } ctrl_stat_t;

  // even parity over a zero-extended word
  function automatic logic even_par(input logic [15:0] w);
    return ^w;
  endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W    = 8,
  parameter int PARITY_EN = 1,
  parameter int OVS       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              txd,
  output logic              hold_free,
  output logic              load,
  output logic              busy
);
  import sio_pkg::*;

  localparam int FRAME_W = DATA_W + PARITY_EN + 2;
  localparam int CNT_W   = $clog2(OVS);
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  // frame image, bit 0 leaves the line first
  function automatic logic [FRAME_W-1:0] make_frame(input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = d;
    if (PARITY_EN != 0) f[DATA_W+1] = even_par(16'(d));
    return f;
  endfunction

  logic [DATA_W-1:0]  hold_q;
  logic               full_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               busy_q;
  logic [CNT_W-1:0]   os_q;
  logic [BCNT_W-1:0]  bit_q;
  logic               bit_end, frame_end;

  assign bit_end   = busy_q && tick && (os_q == CNT_W'(OVS-1));
  assign frame_end = bit_end && (bit_q == BCNT_W'(FRAME_W-1));
  assign load      = en && full_q && (!busy_q || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      busy_q  <= 1'b0;
      os_q    <= '0;
      bit_q   <= '0;
    end else if (load) begin
      shreg_q <= make_frame(hold_q);
      busy_q  <= 1'b1;
      os_q    <= '0;
      bit_q   <= '0;
    end else if (frame_end) begin
      shreg_q <= '1;
      busy_q  <= 1'b0;
      os_q    <= '0;
    end else if (bit_end) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      bit_q   <= bit_q + 1'b1;
      os_q    <= '0;
    end else if (busy_q && tick) begin
      os_q <= os_q + 1'b1;
    end
  end

  // a bus write in the load cycle refills the emptied holder
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (hold_wr) begin
      hold_q <= hold_data;
      full_q <= 1'b1;
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  assign txd       = shreg_q[0];
  assign hold_free = !full_q;
  assign busy      = busy_q;
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DATA_W    = 8,
  parameter int PARITY_EN = 1,
  parameter int OVS       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ninth,
  output logic              frame_err,
  output logic              par_err
);
  import sio_pkg::*;

  localparam int PAY_W  = DATA_W + PARITY_EN;
  localparam int CNT_W  = $clog2(OVS);
  localparam int BCNT_W = $clog2(PAY_W + 1);
  localparam int HALF   = OVS / 2;

  logic              sync1_q, sync2_q;
  rx_state_e         st_q;
  logic [CNT_W-1:0]  os_q;
  logic [BCNT_W-1:0] bit_q;
  logic [PAY_W-1:0]  shreg_q;
  logic              os_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
    end
  end

  assign os_last = (os_q == CNT_W'(OVS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
    end else if (!en) begin
      st_q <= RX_IDLE;
      os_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: if (!sync2_q) begin
          st_q <= RX_START;
          os_q <= '0;
        end
        RX_START: if (tick) begin
          if (os_q == CNT_W'(HALF-1)) begin
            os_q  <= '0;
            bit_q <= '0;
            st_q  <= sync2_q ? RX_IDLE : RX_DATA;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_last) begin
            os_q    <= '0;
            shreg_q <= {sync2_q, shreg_q[PAY_W-1:1]};
            if (bit_q == BCNT_W'(PAY_W-1)) st_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_last) begin
            os_q <= '0;
            st_q <= RX_IDLE;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign done      = en && (st_q == RX_STOP) && tick && os_last;
  assign frame_err = !sync2_q;
  assign data      = shreg_q[DATA_W-1:0];

  generate
    if (PARITY_EN != 0) begin : g_par
      assign ninth   = shreg_q[PAY_W-1];
      assign par_err = even_par(16'(shreg_q));
    end else begin : g_nopar
      assign ninth   = 1'b0;
      assign par_err = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sio_csr.sv
module sio_csr #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [1:0]            bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic                  tx_free,
  input  logic                  rx_done,
  input  logic [DATA_W-1:0]     rx_data,
  input  logic                  rx_ninth,
  input  logic                  rx_ferr,
  input  logic                  rx_perr,
  output logic                  tx_on,
  output logic                  rx_on,
  output logic                  hold_wr,
  output logic                  rd_low,
  output logic                  rx_off,
  output sio_pkg::ctrl_stat_t   stat,
  output logic [15:0]           rx_word
);
  import sio_pkg::*;

  localparam int RXB_W = 16;

  logic ctrl_wr, accept, overrun;
  logic tx_on_q, rx_on_q, full_q, ovr_q, frm_q, par_q;
  logic [RXB_W-1:0] word_q;
  logic unused_wbits;

  assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
  assign hold_wr = bus_wr && (bus_addr == ADR_TXH);
  assign rd_low  = bus_rd && (bus_addr == ADR_RXLO);
  assign rx_off  = ctrl_wr && !bus_wdata[2];
  assign accept  = rx_done && (!full_q || rd_low);
  assign overrun = rx_done && full_q && !rd_low;
  assign unused_wbits = ^{bus_wdata[7:3], bus_wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on_q <= 1'b0;
      rx_on_q <= 1'b0;
    end else if (ctrl_wr) begin
      tx_on_q <= bus_wdata[0];
      rx_on_q <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
      word_q <= '0;
    end else if (rx_off) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      if (accept) begin
        word_q <= RXB_W'({rx_ninth, rx_data});
        full_q <= 1'b1;
        frm_q  <= frm_q | rx_ferr;
        par_q  <= par_q | rx_perr;
      end else if (rd_low) begin
        full_q <= 1'b0;
      end
      if (overrun) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    stat.tx_on   = tx_on_q;
    stat.tx_free = tx_free;
    stat.rx_on   = rx_on_q;
    stat.rx_full = full_q;
    stat.ovr_err = ovr_q;
    stat.frm_err = frm_q;
    stat.par_err = par_q;
    stat.err_any = ovr_q | frm_q | par_q;
  end

  always_comb begin
    case (bus_addr)
      ADR_CTRL: bus_rdata = stat;
      ADR_RXLO: bus_rdata = word_q[7:0];
      ADR_RXHI: bus_rdata = word_q[15:8];
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign tx_on   = tx_on_q;
  assign rx_on   = rx_on_q;
  assign rx_word = word_q;
endmodule

// File: rtl/sio_duplex.sv
module sio_duplex #(
  parameter int DATA_W    = 8,
  parameter int PARITY_EN = 1,
  parameter int OVS       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  output logic       txd,
  input  logic       rxd
);
  import sio_pkg::*;

  // named internal events
  logic              tx_on, rx_on, hold_wr, rd_low, rx_off;
  logic              tx_free, tx_load, tx_busy;
  logic              rx_done, rx_ninth, rx_ferr, rx_perr;
  logic [DATA_W-1:0] rx_data;
  ctrl_stat_t        stat;
  logic [15:0]       rx_word;

  sio_csr #(.DATA_W(DATA_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_free(tx_free),
    .rx_done(rx_done), .rx_data(rx_data), .rx_ninth(rx_ninth),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .tx_on(tx_on), .rx_on(rx_on), .hold_wr(hold_wr),
    .rd_low(rd_low), .rx_off(rx_off), .stat(stat), .rx_word(rx_word)
  );

  sio_tx #(.DATA_W(DATA_W), .PARITY_EN(PARITY_EN), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_on),
    .hold_wr(hold_wr), .hold_data(bus_wdata[DATA_W-1:0]),
    .txd(txd), .hold_free(tx_free), .load(tx_load), .busy(tx_busy)
  );

  sio_rx #(.DATA_W(DATA_W), .PARITY_EN(PARITY_EN), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_on), .rxd(rxd),
    .done(rx_done), .data(rx_data), .ninth(rx_ninth),
    .frame_err(rx_ferr), .par_err(rx_perr)
  );
endmodule

// File: rtl/sio_duplex_chk.sv
module sio_duplex_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txd,
  input logic        tx_load,
  input logic        tx_busy,
  input logic        hold_wr,
  input logic        rd_low,
  input logic        rx_off,
  input logic        rx_done,
  input logic [7:0]  stat,
  input logic [15:0] rx_word,
  input logic        ctrl_wr_rx_on
);
  // stat bits: 7 err_any, 6 par, 5 frm, 4 ovr, 3 rx_full, 2 rx_on, 1 tx_free, 0 tx_on

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !txd);

  assert_free_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !hold_wr |=> stat[1]);

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && tx_load |=> tx_busy && !txd);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_low && !rx_done && !rx_off |=> !stat[3]);

  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && stat[3] && !rd_low && !rx_off |=> stat[4] && $stable(rx_word));

  assert_rx_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_off |=> (stat[7:3] == 5'b0) && !rx_done);

  assert_ro_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_rx_on && !rx_done |=> $stable(stat[6:4]));
endmodule

bind sio_duplex sio_duplex_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_load(tx_load), .tx_busy(tx_busy),
  .hold_wr(hold_wr), .rd_low(rd_low), .rx_off(rx_off), .rx_done(rx_done),
  .stat(stat), .rx_word(rx_word),
  .ctrl_wr_rx_on(bus_wr && (bus_addr == 2'd0) && bus_wdata[2])
);

// File: tb/sio_duplex_bench.sv
module sio_duplex_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       txd;
  logic       rxd = 1'b1;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sio_duplex u_sio_duplex (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_start();
    int n = 0;
    while (txd !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk("R2 start never seen", 8'(txd), 8'h00);
  endtask

  // entered at mid start bit, leaves at mid stop bit; act 1 queues nxt, 2 disables tx
  task automatic tx_bits(input logic [7:0] d, input int act, input logic [7:0] nxt, input string req);
    chk({req, " start"}, 8'(txd), 8'h00);
    if (act == 1) wr(2'd1, nxt);
    else if (act == 2) wr(2'd0, 8'h00);
    repeat ((act != 0) ? 15 : 16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R2 data bit %0d of %02h", i, d), 8'(txd), 8'(d[i]));
      repeat (16) @(negedge clk);
    end
    chk("R2 parity", 8'(txd), 8'(^d));
    repeat (16) @(negedge clk);
    chk("R2 stop", 8'(txd), 8'h01);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    rxd = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (16) @(negedge clk); end
    rxd = (^d) ^ bad_par; repeat (16) @(negedge clk);
    rxd = !bad_stop; repeat (16) @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    baud_tick = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(2'd0, 8'h02, "R1 status after reset");
    chk("R1 txd idle", 8'(txd), 8'h01);

    // R11 only enables are writable
    wr(2'd0, 8'hFF);
    rd_chk(2'd0, 8'h07, "R11 write all ones");
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h02, "R11 write zeros");

    // R3 holder stays while disabled
    wr(2'd1, 8'h5A);
    rd_chk(2'd0, 8'h00, "R3 empty clears on write");
    repeat (40) @(negedge clk);
    chk("R3 no send while disabled", 8'(txd), 8'h01);
    rd_chk(2'd0, 8'h00, "R3 holder kept while disabled");
    wr(2'd0, 8'h01);
    wait_start();
    rd_chk(2'd0, 8'h03, "R3 empty sets on transfer");
    repeat (7) @(negedge clk);
    tx_bits(8'h5A, 0, 8'h00, "R2");

    // R2/R4 sweep of all bytes, back to back
    wr(2'd1, 8'h00);
    wait_start();
    repeat (8) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      tx_bits(8'(i), (i < 255) ? 1 : 0, 8'(i + 1), (i == 0) ? "R2" : "R4 no gap");
      if (i < 255) repeat (16) @(negedge clk);
    end

    // R5 disable mid frame
    repeat (20) @(negedge clk);
    wr(2'd1, 8'h3C);
    wait_start();
    repeat (8) @(negedge clk);
    tx_bits(8'h3C, 2, 8'h00, "R5");
    wr(2'd1, 8'h99);
    begin
      logic seen_low = 1'b0;
      for (int i = 0; i < 120; i++) begin
        if (txd !== 1'b1) seen_low = 1'b1;
        @(negedge clk);
      end
      chk("R5 line idle while disabled", 8'(seen_low), 8'h00);
    end
    rd_chk(2'd0, 8'h00, "R5 holder still full");
    wr(2'd0, 8'h01);
    wait_start();
    repeat (8) @(negedge clk);
    tx_bits(8'h99, 0, 8'h00, "R5 resumed");
    repeat (20) @(negedge clk);

    // R6/R7 receive sweep
    wr(2'd0, 8'h04);
    for (int b = 0; b < 256; b++) begin
      send_rx(8'(b), 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rd_chk(2'd3, 8'(^8'(b)), "R6 high byte parity bit");
      rd_chk(2'd0, 8'h0E, "R7 high read keeps complete");
      rd_chk(2'd2, 8'(b), "R6 low byte data");
      rd_chk(2'd0, 8'h06, "R7 low read clears complete");
    end

    // R8 overrun
    send_rx(8'h11, 1'b0, 1'b0);
    send_rx(8'h22, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 8'h9E, "R8 overrun flagged");
    rd_chk(2'd2, 8'h11, "R8 old word kept");
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h02, "R10 disable clears flags");
    wr(2'd0, 8'h04);

    // R8 completion in the same cycle as a low read
    send_rx(8'h33, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    fork
      send_rx(8'h44, 1'b0, 1'b0);
      begin
        repeat (170) @(negedge clk);
        rd_chk(2'd2, 8'h33, "R8 same-cycle read returns old");
      end
    join
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 8'h0E, "R8 same-cycle no overrun");
    rd_chk(2'd2, 8'h44, "R8 same-cycle new word stored");

    // R9 framing and parity errors
    send_rx(8'h55, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    rd_chk(2'd0, 8'hAE, "R9 framing error");
    rd_chk(2'd2, 8'h55, "R9 framed data");
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h04);
    send_rx(8'h55, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 8'hCE, "R9 parity error");
    rd_chk(2'd3, 8'h01, "R9 bad parity bit seen");

    // R10 abort mid frame
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h02, "R10 errors cleared");
    wr(2'd0, 8'h04);
    fork
      send_rx(8'h77, 1'b0, 1'b0);
      begin
        repeat (80) @(negedge clk);
        wr(2'd0, 8'h00);
      end
    join
    wr(2'd0, 8'h04);
    repeat (30) @(negedge clk);
    rd_chk(2'd0, 8'h06, "R10 aborted frame never completes");
    send_rx(8'h78, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 8'h0E, "R10 receiver recovers");
    rd_chk(2'd2, 8'h78, "R10 recovered data");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule